// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Acceptor

This block is the interrupt-acceptance stage of a small 8-bit processor core. It watches five request inputs: one non-maskable input, one edge-triggered maskable input with a pending latch, two level-sensitive maskable inputs, and one level-sensitive non-vectored input. The core's sequencer pulses `boundary_i` at the end of every instruction. On that pulse the block picks the single highest-priority request that is eligible. It then reports the choice as a one-cycle `take_o` pulse together with a 16-bit service address. For the non-vectored input it raises an acknowledge request in place of an address.

Eligibility for the maskable inputs is gated at two levels. A global enable is set by an `ei_i` strobe, cleared by a `di_i` strobe, and cleared automatically whenever a maskable request is accepted. Each of the three vectored maskable inputs also has its own mask bit. Software loads the masks and clears the pending latch through an 8-bit control write. It reads masks, enable, live pins and the latch back through an 8-bit combinational status word.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `status_o` reads 8'h07 with `serial_in_i` low: all three masks set, global enable clear, pending latch clear. `take_o`, `ack_req_o` and `vector_o` are 0.
- R2: A write with `ctl_wdata_i[3]`=1 loads mask bits [2:0] from data bits [2:0]. A write with bit 3 = 0 leaves the masks unchanged. Data bit 5 has no effect on any state.
- R3: Mask bit 0 gates `irq_lo_i`, bit 1 gates `irq_mid_i` and bit 2 gates `irq_hi_i`. A 1 blocks the source and a 0 allows it.
- R4: An `ei_i` pulse sets the global enable and a `di_i` pulse clears it. The four maskable sources are accepted only while it is set, and accepting any of them clears it.
- R5: A rising edge on `irq_hi_i` sets a pending latch even while that source is masked. The latch stays set after the pin drops, leads to acceptance once the source is unmasked and enabled, and clears on that acceptance.
- R6: A control write with data bit 4 = 1 clears the pending latch without any acceptance.
- R7: `irq_mid_i`, `irq_lo_i` and `irq_ext_i` are level-sensitive without memory. A request that drops before the boundary pulse is not accepted.
- R8: `status_o` bits: [2:0] masks (lo, mid, hi), [3] global enable, [4] live `irq_lo_i`, [5] live `irq_mid_i`, [6] pending latch, [7] `serial_in_i`.
- R9: Service addresses are 16'h0024 (`nmi_i`), 16'h003C (`irq_hi_i`), 16'h0034 (`irq_mid_i`) and 16'h002C (`irq_lo_i`). Accepting `irq_ext_i` raises `ack_req_o` with `vector_o` = 0.
- R10: `nmi_i` ignores the enable and the masks. It is accepted only while still high after a captured rising edge. After acceptance it is not accepted again until it has gone low and then high. Its acceptance does not change the global enable.
- R11: When several requests are eligible, priority runs `nmi_i`, `irq_hi_i`, `irq_mid_i`, `irq_lo_i`, `irq_ext_i`.
- R12: Requests are evaluated only on a `boundary_i` pulse. At most one acceptance results, and `take_o` is high for exactly the one cycle following that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | Instruction-boundary evaluation strobe |
| ei_i | input | 1 | Set global enable |
| di_i | input | 1 | Clear global enable |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 8 | Control write data (masks, mask-load, latch clear) |
| status_o | output | 8 | Status read word |
| serial_in_i | input | 1 | Serial input pin reported in status |
| nmi_i | input | 1 | Non-maskable request |
| irq_hi_i | input | 1 | Edge-latched maskable request |
| irq_mid_i | input | 1 | Level maskable request, middle priority |
| irq_lo_i | input | 1 | Level maskable request, low priority |
| irq_ext_i | input | 1 | Level non-vectored request |
| take_o | output | 1 | One-cycle acceptance pulse |
| vector_o | output | 16 | Service address of accepted request |
| ack_req_o | output | 1 | Acknowledge request for non-vectored acceptance |

## Verification
Control writes and enable strobes register on one clock edge and show on `status_o` at the falling edge that follows. Live pins reach `status_o` combinationally. The two edge-qualified inputs need one clock edge to capture their rise, so the bench holds every source stable for three cycles before it pulses `boundary_i`. Acceptance results are registered on the edge that samples the strobe. The bench samples them at the falling edge right after that edge, then checks one cycle later that the pulse has already ended.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int NUM_SRC = 5;
   // Priority index: lower index wins
   localparam int IDX_NMI = 0;
   localparam int IDX_HI  = 1;
   localparam int IDX_MID = 2;
   localparam int IDX_LO  = 3;
   localparam int IDX_EXT = 4;
   // Control write field positions
   localparam int CW_MASK_LO  = 0;
   localparam int CW_MASK_HI  = 2;
   localparam int CW_MASK_LD  = 3;
   localparam int CW_PEND_CLR = 4;
   // Status word field positions
   localparam int ST_IE     = 3;
   localparam int ST_LO_PIN = 4;
   localparam int ST_MID_PIN= 5;
   localparam int ST_PEND   = 6;
   localparam int ST_SERIAL = 7;
   localparam int NUM_MASK  = CW_MASK_HI - CW_MASK_LO + 1;
endpackage

// File: rtl/irqc_edge_latch.sv
module irqc_edge_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   input  logic clr_i,
   output logic pend_o
);
   logic prev_q;
   logic pend_q;
   logic rise;

   assign rise = sig_i & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= sig_i;
         if (rise)
            pend_q <= 1'b1;
         else if (clr_i)
            pend_q <= 1'b0;
      end
   end

   assign pend_o = pend_q;

   // R5
   pend_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sig_i && !prev_q) |=> pend_q);
   // R6
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !(sig_i && !prev_q)) |=> !pend_q);
endmodule

// File: rtl/irqc_nmi_qual.sv
module irqc_nmi_qual #(
   parameter bit LEVEL_QUAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   input  logic accept_i,
   output logic ready_o
);
   logic prev_q;
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         prev_q <= sig_i;
         if (sig_i && !prev_q)
            armed_q <= 1'b1;
         else if (accept_i)
            armed_q <= 1'b0;
         else if (LEVEL_QUAL && !sig_i)
            armed_q <= 1'b0;
      end
   end

   generate
      if (LEVEL_QUAL) begin : g_level
         assign ready_o = armed_q & sig_i;
      end else begin : g_edge
         assign ready_o = armed_q;
      end
   endgenerate

   // R10
   nmi_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_i && !(sig_i && !prev_q)) |=> !armed_q);
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
   parameter int N = 5
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] grant_o,
   output logic         valid_o
);
   logic [N-1:0] above;

   assign above[0]   = 1'b0;
   assign grant_o[0] = req_i[0];

   generate
      for (genvar i = 1; i < N; i++) begin : g_chain
         assign above[i]   = above[i-1] | req_i[i-1];
         assign grant_o[i] = req_i[i] & ~above[i];
      end
   endgenerate

   assign valid_o = |req_i;

   // R11
   always_comb begin
      grant_onehot_chk: assert ($onehot0(grant_o));
   end
endmodule

// File: rtl/irqc_ctl_regs.sv
module irqc_ctl_regs #(
   parameter int MASK_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ei_i,
   input  logic              di_i,
   input  logic              wr_i,
   input  logic              mask_ld_i,
   input  logic [MASK_W-1:0] mask_d_i,
   input  logic              accept_mask_i,
   output logic [MASK_W-1:0] mask_o,
   output logic              ie_o
);
   logic [MASK_W-1:0] mask_q;
   logic              ie_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
         ie_q   <= 1'b0;
      end else begin
         if (wr_i && mask_ld_i)
            mask_q <= mask_d_i;
         if (accept_mask_i)
            ie_q <= 1'b0;
         else if (di_i)
            ie_q <= 1'b0;
         else if (ei_i)
            ie_q <= 1'b1;
      end
   end

   assign mask_o = mask_q;
   assign ie_o   = ie_q;

   // R4
   ie_clear_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept_mask_i |=> !ie_q);
   // R2
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_i && mask_ld_i) |=> $stable(mask_q));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
   import irqc_pkg::*;
#(
   parameter int          ADDR_W         = 16,
   parameter int          DATA_W         = 8,
   parameter int unsigned VEC_NMI        = 32'h0024,
   parameter int unsigned VEC_HI         = 32'h003C,
   parameter int unsigned VEC_MID        = 32'h0034,
   parameter int unsigned VEC_LO         = 32'h002C,
   parameter bit          NMI_LEVEL_QUAL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary_i,
   input  logic              ei_i,
   input  logic              di_i,
   input  logic              ctl_wr_i,
   input  logic [DATA_W-1:0] ctl_wdata_i,
   output logic [DATA_W-1:0] status_o,
   input  logic              serial_in_i,
   input  logic              nmi_i,
   input  logic              irq_hi_i,
   input  logic              irq_mid_i,
   input  logic              irq_lo_i,
   input  logic              irq_ext_i,
   output logic              take_o,
   output logic [ADDR_W-1:0] vector_o,
   output logic              ack_req_o
);
   localparam int MAX_VEC = (VEC_NMI > VEC_HI ? VEC_NMI : VEC_HI) >
                            (VEC_MID > VEC_LO ? VEC_MID : VEC_LO) ?
                            (VEC_NMI > VEC_HI ? VEC_NMI : VEC_HI) :
                            (VEC_MID > VEC_LO ? VEC_MID : VEC_LO);

   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("vec_irq_ctrl: DATA_W must be 8");
      end
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("vec_irq_ctrl: ADDR_W out of range");
      end
      if (ADDR_W < 32 && MAX_VEC >= (64'd1 << ADDR_W)) begin : g_bad_vec
         $error("vec_irq_ctrl: vector does not fit ADDR_W");
      end
   endgenerate

   logic [NUM_MASK-1:0] mask;
   logic                ie;
   logic                pend_hi;
   logic                nmi_ready;
   logic [NUM_SRC-1:0]  req;
   logic [NUM_SRC-1:0]  grant;
   logic                any_req;
   logic                accept_any;
   logic                accept_mask;
   logic                pend_clr;
   logic [ADDR_W-1:0]   vec_sel;
   logic                take_q;
   logic                ack_q;
   logic [ADDR_W-1:0]   vec_q;
   logic                unused_wdata;

   assign unused_wdata = ^ctl_wdata_i[DATA_W-1:CW_PEND_CLR+1];

   irqc_ctl_regs #(.MASK_W(NUM_MASK)) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .ei_i          (ei_i),
      .di_i          (di_i),
      .wr_i          (ctl_wr_i),
      .mask_ld_i     (ctl_wdata_i[CW_MASK_LD]),
      .mask_d_i      (ctl_wdata_i[CW_MASK_HI:CW_MASK_LO]),
      .accept_mask_i (accept_mask),
      .mask_o        (mask),
      .ie_o          (ie)
   );

   assign pend_clr = (ctl_wr_i & ctl_wdata_i[CW_PEND_CLR]) |
                     (boundary_i & grant[IDX_HI]);

   irqc_edge_latch u_hi_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_i  (irq_hi_i),
      .clr_i  (pend_clr),
      .pend_o (pend_hi)
   );

   irqc_nmi_qual #(.LEVEL_QUAL(NMI_LEVEL_QUAL)) u_nmi (
      .clk      (clk),
      .rst_n    (rst_n),
      .sig_i    (nmi_i),
      .accept_i (boundary_i & grant[IDX_NMI]),
      .ready_o  (nmi_ready)
   );

   always_comb begin
      req          = '0;
      req[IDX_NMI] = nmi_ready;
      req[IDX_HI]  = ie & ~mask[2] & pend_hi;
      req[IDX_MID] = ie & ~mask[1] & irq_mid_i;
      req[IDX_LO]  = ie & ~mask[0] & irq_lo_i;
      req[IDX_EXT] = ie & irq_ext_i;
   end

   irqc_prio #(.N(NUM_SRC)) u_prio (
      .req_i   (req),
      .grant_o (grant),
      .valid_o (any_req)
   );

   assign accept_any  = boundary_i & any_req;
   assign accept_mask = boundary_i & (|grant[NUM_SRC-1:IDX_HI]);

   always_comb begin
      vec_sel = '0;
      unique case (1'b1)
         grant[IDX_NMI]: vec_sel = ADDR_W'(VEC_NMI);
         grant[IDX_HI]:  vec_sel = ADDR_W'(VEC_HI);
         grant[IDX_MID]: vec_sel = ADDR_W'(VEC_MID);
         grant[IDX_LO]:  vec_sel = ADDR_W'(VEC_LO);
         default:        vec_sel = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_q <= 1'b0;
         ack_q  <= 1'b0;
         vec_q  <= '0;
      end else begin
         take_q <= accept_any;
         ack_q  <= boundary_i & grant[IDX_EXT];
         vec_q  <= accept_any ? vec_sel : '0;
      end
   end

   assign take_o    = take_q;
   assign ack_req_o = ack_q;
   assign vector_o  = vec_q;

   always_comb begin
      status_o                          = '0;
      status_o[CW_MASK_HI:CW_MASK_LO]   = mask;
      status_o[ST_IE]                   = ie;
      status_o[ST_LO_PIN]               = irq_lo_i;
      status_o[ST_MID_PIN]              = irq_mid_i;
      status_o[ST_PEND]                 = pend_hi;
      status_o[ST_SERIAL]               = serial_in_i;
   end

   // R12
   take_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> $past(boundary_i));
   // R12
   take_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && !boundary_i) |=> !take_o);
   // R9
   ack_no_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req_o |-> (take_o && vector_o == '0));
   // R10
   nmi_keeps_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary_i && grant[IDX_NMI] && !ei_i && !di_i) |=> $stable(ie));
endmodule

// File: tb/tb_vec_irq_ctrl.sv
module tb_vec_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boundary_i = 1'b0, ei_i = 1'b0, di_i = 1'b0, ctl_wr_i = 1'b0;
   logic [7:0]  ctl_wdata_i = '0;
   logic [7:0]  status_o;
   logic        serial_in_i = 1'b0;
   logic        nmi_i = 1'b0, irq_hi_i = 1'b0, irq_mid_i = 1'b0, irq_lo_i = 1'b0, irq_ext_i = 1'b0;
   logic        take_o, ack_req_o;
   logic [15:0] vector_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5ns clk = ~clk;

   vec_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .ei_i(ei_i), .di_i(di_i),
      .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i), .status_o(status_o),
      .serial_in_i(serial_in_i), .nmi_i(nmi_i), .irq_hi_i(irq_hi_i),
      .irq_mid_i(irq_mid_i), .irq_lo_i(irq_lo_i), .irq_ext_i(irq_ext_i),
      .take_o(take_o), .vector_o(vector_o), .ack_req_o(ack_req_o)
   );

   // row: mask[2:0], ei, src{nmi,hi,mid,lo,ext}, exp_take, exp_ack, exp_vec[15:0]
   localparam int NROWS = 13;
   localparam logic [26:0] TBL [0:NROWS-1] = '{
      {3'b000, 1'b1, 5'b01000, 1'b1, 1'b0, 16'h003C},
      {3'b000, 1'b1, 5'b00100, 1'b1, 1'b0, 16'h0034},
      {3'b000, 1'b1, 5'b00010, 1'b1, 1'b0, 16'h002C},
      {3'b000, 1'b1, 5'b00001, 1'b1, 1'b1, 16'h0000},
      {3'b000, 1'b0, 5'b00100, 1'b0, 1'b0, 16'h0000},
      {3'b111, 1'b1, 5'b00110, 1'b0, 1'b0, 16'h0000},
      {3'b010, 1'b1, 5'b00110, 1'b1, 1'b0, 16'h002C},
      {3'b111, 1'b0, 5'b10000, 1'b1, 1'b0, 16'h0024},
      {3'b000, 1'b1, 5'b11111, 1'b1, 1'b0, 16'h0024},
      {3'b000, 1'b1, 5'b01111, 1'b1, 1'b0, 16'h003C},
      {3'b100, 1'b1, 5'b01111, 1'b1, 1'b0, 16'h0034},
      {3'b110, 1'b1, 5'b00111, 1'b1, 1'b0, 16'h002C},
      {3'b111, 1'b1, 5'b00011, 1'b1, 1'b1, 16'h0000}
   };

   task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      {boundary_i, ei_i, di_i, ctl_wr_i} = '0;
      ctl_wdata_i = '0;
      {nmi_i, irq_hi_i, irq_mid_i, irq_lo_i, irq_ext_i, serial_in_i} = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic ctl_write(input logic [7:0] d);
      @(negedge clk);
      ctl_wr_i = 1'b1; ctl_wdata_i = d;
      @(negedge clk);
      ctl_wr_i = 1'b0; ctl_wdata_i = '0;
   endtask

   task automatic pulse_ei();
      @(negedge clk); ei_i = 1'b1;
      @(negedge clk); ei_i = 1'b0;
   endtask

   task automatic pulse_di();
      @(negedge clk); di_i = 1'b1;
      @(negedge clk); di_i = 1'b0;
   endtask

   task automatic strobe();
      @(negedge clk); boundary_i = 1'b1;
      @(negedge clk); boundary_i = 1'b0;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #2ms;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      do_reset();
      chk(status_o, 8'h07, "R1 status");
      chk({take_o, ack_req_o}, 0, "R1 take/ack");
      chk(vector_o, 0, "R1 vector");

      // Table: R3 R4 R9 R11 R10
      for (int i = 0; i < NROWS; i++) begin
         do_reset();
         ctl_write({5'b00001, TBL[i][26:24]});
         if (TBL[i][23]) pulse_ei();
         @(negedge clk);
         {nmi_i, irq_hi_i, irq_mid_i, irq_lo_i, irq_ext_i} = TBL[i][22:18];
         settle();
         strobe();
         chk(take_o, TBL[i][17], $sformatf("R11 row%0d take", i));
         chk(ack_req_o, TBL[i][16], $sformatf("R9 row%0d ack", i));
         chk(vector_o, TBL[i][15:0], $sformatf("R9 row%0d vector", i));
      end

      // R2 mask load enable and ignored bit 5
      do_reset();
      ctl_write(8'h0D);
      chk(status_o[2:0], 3'b101, "R2 load");
      ctl_write(8'h02);
      chk(status_o[2:0], 3'b101, "R2 hold without load bit");
      ctl_write(8'h28);
      chk(status_o, 8'h00, "R2 bit5 ignored");

      // R4 enable strobes and auto clear
      pulse_ei();
      chk(status_o[3], 1, "R4 ei sets");
      pulse_di();
      chk(status_o[3], 0, "R4 di clears");
      pulse_ei();
      @(negedge clk); irq_lo_i = 1'b1;
      settle();
      strobe();
      chk(take_o, 1, "R4 accept");
      chk(status_o[3], 0, "R4 accept clears enable");
      irq_lo_i = 1'b0;

      // R5 edge latch while masked
      do_reset();
      pulse_ei();
      @(negedge clk); irq_hi_i = 1'b1;
      @(negedge clk); irq_hi_i = 1'b0;
      chk(status_o[6], 1, "R5 latched while masked");
      strobe();
      chk(take_o, 0, "R5 masked no take");
      ctl_write(8'h0B);
      strobe();
      chk(vector_o, 16'h003C, "R5 accepted after unmask");
      chk(status_o[6], 0, "R5 latch cleared on accept");

      // R6 explicit latch clear
      do_reset();
      @(negedge clk); irq_hi_i = 1'b1;
      @(negedge clk); irq_hi_i = 1'b0;
      ctl_write(8'h10);
      chk(status_o, 8'h07, "R6 latch cleared, masks kept");
      ctl_write(8'h08);
      pulse_ei();
      strobe();
      chk(take_o, 0, "R6 no take after clear");

      // R7 level sources have no memory; R8 live pins and serial bit
      do_reset();
      ctl_write(8'h08);
      pulse_ei();
      @(negedge clk); irq_mid_i = 1'b1; serial_in_i = 1'b1;
      #1ns;
      chk(status_o, 8'hA8, "R8 live pins");
      @(negedge clk); irq_mid_i = 1'b0; irq_ext_i = 1'b1;
      @(negedge clk); irq_ext_i = 1'b0;
      strobe();
      chk(take_o, 0, "R7 dropped levels not accepted");
      chk(status_o[3], 1, "R7 enable kept");

      // R10 non-maskable once per rising edge; enable unaffected
      do_reset();
      pulse_ei();
      @(negedge clk); nmi_i = 1'b1;
      settle();
      strobe();
      chk(vector_o, 16'h0024, "R10 first accept");
      chk(status_o[3], 1, "R10 enable unchanged");
      strobe();
      chk(take_o, 0, "R10 no repeat while held");
      @(negedge clk); nmi_i = 1'b0;
      @(negedge clk); nmi_i = 1'b1;
      settle();
      strobe();
      chk(take_o, 1, "R10 re-accept after new edge");
      @(negedge clk); nmi_i = 1'b0;
      @(negedge clk); nmi_i = 1'b1;
      @(negedge clk); nmi_i = 1'b0;
      settle();
      strobe();
      chk(take_o, 0, "R10 dropped before boundary");

      // R12 only on boundary, one-cycle pulse
      do_reset();
      ctl_write(8'h08);
      pulse_ei();
      @(negedge clk); irq_mid_i = 1'b1;
      settle();
      chk(take_o, 0, "R12 no take without boundary");
      strobe();
      chk(take_o, 1, "R12 take after boundary");
      @(negedge clk);
      chk(take_o, 0, "R12 single cycle");
      irq_mid_i = 1'b0;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule